// File: doc/BRIEF.md
# Operand Pipeline Register-Busy Interlock

This block detects change/use hazards in a five-stage in-order operand pipeline and holds the dependent instruction at the front. The stages, in order, are decode/select (DS), address generation (AG), two operand stages (OP1, OP2) and execute (EX). Each instruction that leaves DS is tracked through AG, OP1, OP2 and EX. The tracker keeps a valid flag, a write flag, a 4-bit destination index and a flag marking a memory-load result. Register indices 0 to 7 name the data registers and 8 to 15 name the address registers.

An instruction in DS may read a base register in its first address cycle and an index register in its second address cycle. If a source matches a pending write whose value is not yet usable, the block raises `stall`. The DS instruction and fetch then hold, and a bubble goes into AG. A result computed in the execute stage can be used once its producer reaches EX. A memory-load result can be sent from OP2 straight back to DS. The block drives that forward select for the base operand.

Two configuration inputs switch off branch folding and move-pair dual dispatch. The fold strobes are granted only when the instruction issues.

Top module: `regbusy_interlock`

## Requirements
- R1: After reset no write is pending. `oagValid` is 0, and a DS instruction with any sources sees `stall` = 0.
- R2: `stall` is 0 in two cases: when `dsValid` is 0, and when no in-flight write matches a used source.
- R3: An execute-result write to register r, followed at once by a DS instruction that uses r as its base, gives exactly 3 stall cycles.
- R4: A load write (`dsDestFromLoad` = 1) to r, followed at once by a base use of r, gives exactly 2 stall cycles.
- R5: `fwdBaseOc2` is 1 in the cycle a base-using instruction issues while the youngest matching write is a load in OP2. It is 0 when the youngest match is not such a load.
- R6: An index source is read one cycle later than a base source. An execute-result producer directly ahead therefore costs 2 stall cycles, and a load producer costs 1.
- R7: When several in-flight writes target the same register, only the youngest one sets the stall and forward status.
- R8: `foldBranch` equals `dsValid & dsBranchPair & ~cfgBranchFoldOff & ~stall`. `foldMove` equals `dsValid & dsMovePair & ~cfgMovePairOff & ~stall`. A configuration bit set to 1 disables its folding, and both bits at 0 allow it.
- R9: While `stall` is 1, nothing enters AG. `oagValid` is 0 in the cycle after each stall cycle.
- R10: An in-flight instruction with `dsDestWr` = 0 creates no hazard. Stall length also shrinks by one for each instruction between producer and consumer.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dsValid | input | 1 | DS holds an instruction |
| dsBaseUse | input | 1 | DS instruction reads a base register in its first address cycle |
| dsBaseReg | input | 4 | Base register index |
| dsIdxUse | input | 1 | DS instruction reads an index register in its second address cycle |
| dsIdxReg | input | 4 | Index register index |
| dsDestWr | input | 1 | DS instruction writes a register |
| dsDestReg | input | 4 | Destination register index |
| dsDestFromLoad | input | 1 | Destination value comes from a memory load |
| dsBranchPair | input | 1 | DS instruction is a branch-fold candidate |
| dsMovePair | input | 1 | DS instruction is a move-pair candidate |
| cfgBranchFoldOff | input | 1 | 1 disables branch folding |
| cfgMovePairOff | input | 1 | 1 disables move-pair dual dispatch |
| stall | output | 1 | Hold DS and fetch; insert a bubble into AG |
| fwdBaseOc2 | output | 1 | Select the OP2 load result as the DS base operand |
| oagValid | output | 1 | AG stage holds a valid instruction |
| foldBranch | output | 1 | Branch folding granted this cycle |
| foldMove | output | 1 | Move-pair dual dispatch granted this cycle |

## Verification
The hardest case to reach is one where two in-flight writes to the same register sit in different stages with different availability. One is an execute result and the other is a load. Only the younger may decide whether the consumer stalls and whether the OP2 forward path is chosen. The bench builds this by issuing two back-to-back producers with the same destination, in both orders, and then presents the consumer at once. It checks both the stall length and the forward select in the release cycle.

// File: rtl/regbusy_pkg.sv
package regbusy_pkg;
  localparam int IDX_W = 4;

  typedef struct packed {
    logic             vld;
    logic             wr;
    logic [IDX_W-1:0] dst;
    logic             ld;
  } stageTag_t;

  typedef struct packed {
    logic issue;
    logic bubble;
  } ctlStrobe_t;
endpackage

// File: rtl/regbusy_track.sv
module regbusy_track
  import regbusy_pkg::*;
#(
  parameter int NUM_INFLIGHT = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  ctlStrobe_t                    strobe,
  input  logic                          dsDestWr,
  input  logic [IDX_W-1:0]              dsDestReg,
  input  logic                          dsDestFromLoad,
  output stageTag_t [NUM_INFLIGHT-1:0]  stages
);
  stageTag_t [NUM_INFLIGHT-1:0] stageQ;
  stageTag_t                    entryTag;

  always_comb begin
    entryTag     = '0;
    entryTag.vld = strobe.issue & ~strobe.bubble;
    entryTag.wr  = entryTag.vld & dsDestWr;
    entryTag.dst = dsDestReg;
    entryTag.ld  = dsDestFromLoad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stageQ[0] <= '0;
    else        stageQ[0] <= entryTag;
  end

  for (genvar s = 1; s < NUM_INFLIGHT; s++) begin : gShift
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stageQ[s] <= '0;
      else        stageQ[s] <= stageQ[s-1];
    end
  end

  assign stages = stageQ;
endmodule

// File: rtl/regbusy_hazard.sv
module regbusy_hazard
  import regbusy_pkg::*;
#(
  parameter int NUM_INFLIGHT   = 4,
  parameter int EXEC_AVAIL_STG = 3,
  parameter int LOAD_AVAIL_STG = 2,
  parameter int IDX_LAG        = 1
) (
  input  stageTag_t [NUM_INFLIGHT-1:0] stages,
  input  logic                         dsValid,
  input  logic                         dsBaseUse,
  input  logic [IDX_W-1:0]             dsBaseReg,
  input  logic                         dsIdxUse,
  input  logic [IDX_W-1:0]             dsIdxReg,
  input  logic                         dsBranchPair,
  input  logic                         dsMovePair,
  input  logic                         cfgBranchFoldOff,
  input  logic                         cfgMovePairOff,
  output ctlStrobe_t                   strobe,
  output logic                         stall,
  output logic                         fwdBaseOc2,
  output logic                         foldBranch,
  output logic                         foldMove
);
  localparam int STG_W = $clog2(NUM_INFLIGHT + 1);

  logic [NUM_INFLIGHT-1:0] baseHit, idxHit;
  logic                    baseFound, idxFound;
  logic [STG_W-1:0]        baseStg, idxStg;
  logic                    baseLd, idxLd;
  logic                    baseBusy, idxBusy, baseFwd;

  for (genvar s = 0; s < NUM_INFLIGHT; s++) begin : gCmp
    assign baseHit[s] = stages[s].wr && (stages[s].dst == dsBaseReg);
    assign idxHit[s]  = stages[s].wr && (stages[s].dst == dsIdxReg);
  end

  // Walk oldest to youngest so the youngest match wins.
  always_comb begin
    baseFound = 1'b0; baseStg = '0; baseLd = 1'b0;
    idxFound  = 1'b0; idxStg  = '0; idxLd  = 1'b0;
    for (int s = NUM_INFLIGHT - 1; s >= 0; s--) begin
      if (baseHit[s]) begin
        baseFound = 1'b1; baseStg = STG_W'(s); baseLd = stages[s].ld;
      end
      if (idxHit[s]) begin
        idxFound = 1'b1; idxStg = STG_W'(s); idxLd = stages[s].ld;
      end
    end
  end

  always_comb begin
    baseBusy = 1'b0;
    idxBusy  = 1'b0;
    if (dsBaseUse && baseFound)
      baseBusy = int'(baseStg) < (baseLd ? LOAD_AVAIL_STG : EXEC_AVAIL_STG);
    if (dsIdxUse && idxFound)
      idxBusy = (int'(idxStg) + IDX_LAG) < (idxLd ? LOAD_AVAIL_STG : EXEC_AVAIL_STG);
    baseFwd = dsBaseUse && baseFound && baseLd && (int'(baseStg) == LOAD_AVAIL_STG);
  end

  assign stall         = dsValid & (baseBusy | idxBusy);
  assign strobe.issue  = dsValid & ~stall;
  assign strobe.bubble = stall;
  assign fwdBaseOc2    = strobe.issue & baseFwd;
  assign foldBranch    = strobe.issue & dsBranchPair & ~cfgBranchFoldOff;
  assign foldMove      = strobe.issue & dsMovePair & ~cfgMovePairOff;
endmodule

// File: rtl/regbusy_interlock.sv
module regbusy_interlock
  import regbusy_pkg::*;
#(
  parameter int NUM_INFLIGHT   = 4,
  parameter int EXEC_AVAIL_STG = 3,
  parameter int LOAD_AVAIL_STG = 2,
  parameter int IDX_LAG        = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dsValid,
  input  logic             dsBaseUse,
  input  logic [IDX_W-1:0] dsBaseReg,
  input  logic             dsIdxUse,
  input  logic [IDX_W-1:0] dsIdxReg,
  input  logic             dsDestWr,
  input  logic [IDX_W-1:0] dsDestReg,
  input  logic             dsDestFromLoad,
  input  logic             dsBranchPair,
  input  logic             dsMovePair,
  input  logic             cfgBranchFoldOff,
  input  logic             cfgMovePairOff,
  output logic             stall,
  output logic             fwdBaseOc2,
  output logic             oagValid,
  output logic             foldBranch,
  output logic             foldMove
);
  stageTag_t [NUM_INFLIGHT-1:0] stages;
  ctlStrobe_t                   strobe;

  regbusy_hazard #(
    .NUM_INFLIGHT(NUM_INFLIGHT), .EXEC_AVAIL_STG(EXEC_AVAIL_STG),
    .LOAD_AVAIL_STG(LOAD_AVAIL_STG), .IDX_LAG(IDX_LAG)
  ) u_ctl (
    .stages(stages), .dsValid(dsValid),
    .dsBaseUse(dsBaseUse), .dsBaseReg(dsBaseReg),
    .dsIdxUse(dsIdxUse), .dsIdxReg(dsIdxReg),
    .dsBranchPair(dsBranchPair), .dsMovePair(dsMovePair),
    .cfgBranchFoldOff(cfgBranchFoldOff), .cfgMovePairOff(cfgMovePairOff),
    .strobe(strobe), .stall(stall), .fwdBaseOc2(fwdBaseOc2),
    .foldBranch(foldBranch), .foldMove(foldMove)
  );

  regbusy_track #(.NUM_INFLIGHT(NUM_INFLIGHT)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .dsDestWr(dsDestWr), .dsDestReg(dsDestReg), .dsDestFromLoad(dsDestFromLoad),
    .stages(stages)
  );

  assign oagValid = stages[0].vld;
endmodule

// File: rtl/regbusy_interlock_chk.sv
module regbusy_interlock_chk #(
  parameter int MAX_STALL = 3
) (
  input logic clk,
  input logic rst_n,
  input logic dsValid,
  input logic stall,
  input logic fwdBaseOc2,
  input logic oagValid,
  input logic foldBranch,
  input logic foldMove,
  input logic cfgBranchFoldOff,
  input logic cfgMovePairOff
);
  int stallRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     stallRun <= 0;
    else if (stall) stallRun <= stallRun + 1;
    else            stallRun <= 0;
  end

  AST_IDLE_NO_STALL:  assert property (@(posedge clk) disable iff (!rst_n) !dsValid |-> !stall);          // R2
  AST_STALL_BOUND:    assert property (@(posedge clk) disable iff (!rst_n) stall |-> stallRun < MAX_STALL); // R3
  AST_FWD_NOT_STALL:  assert property (@(posedge clk) disable iff (!rst_n) fwdBaseOc2 |-> !stall);        // R5
  AST_BRANCH_OFF:     assert property (@(posedge clk) disable iff (!rst_n) (cfgBranchFoldOff || stall) |-> !foldBranch); // R8
  AST_MOVE_OFF:       assert property (@(posedge clk) disable iff (!rst_n) (cfgMovePairOff || stall) |-> !foldMove);     // R8
  AST_BUBBLE:         assert property (@(posedge clk) disable iff (!rst_n) stall |=> !oagValid);          // R9
endmodule

bind regbusy_interlock regbusy_interlock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dsValid(dsValid), .stall(stall),
  .fwdBaseOc2(fwdBaseOc2), .oagValid(oagValid), .foldBranch(foldBranch),
  .foldMove(foldMove), .cfgBranchFoldOff(cfgBranchFoldOff),
  .cfgMovePairOff(cfgMovePairOff)
);

// File: tb/regbusy_interlock_bench.sv
module regbusy_interlock_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dsValid = 0, dsBaseUse = 0, dsIdxUse = 0, dsDestWr = 0, dsDestFromLoad = 0;
  logic [3:0] dsBaseReg = 0, dsIdxReg = 0, dsDestReg = 0;
  logic dsBranchPair = 0, dsMovePair = 0, cfgBranchFoldOff = 0, cfgMovePairOff = 0;
  logic stall, fwdBaseOc2, oagValid, foldBranch, foldMove;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  regbusy_interlock u_regbusy_interlock (
    .clk(clk), .rst_n(rst_n), .dsValid(dsValid),
    .dsBaseUse(dsBaseUse), .dsBaseReg(dsBaseReg),
    .dsIdxUse(dsIdxUse), .dsIdxReg(dsIdxReg),
    .dsDestWr(dsDestWr), .dsDestReg(dsDestReg), .dsDestFromLoad(dsDestFromLoad),
    .dsBranchPair(dsBranchPair), .dsMovePair(dsMovePair),
    .cfgBranchFoldOff(cfgBranchFoldOff), .cfgMovePairOff(cfgMovePairOff),
    .stall(stall), .fwdBaseOc2(fwdBaseOc2), .oagValid(oagValid),
    .foldBranch(foldBranch), .foldMove(foldMove)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Present one instruction at a negedge, hold it while stalled.
  task automatic send(input logic bU, input logic [3:0] bR, input logic iU, input logic [3:0] iR,
                      input logic wr, input logic [3:0] dR, input logic ld,
                      output int stalls, output logic fwd);
    @(negedge clk);
    dsValid = 1; dsBaseUse = bU; dsBaseReg = bR; dsIdxUse = iU; dsIdxReg = iR;
    dsDestWr = wr; dsDestReg = dR; dsDestFromLoad = ld;
    #2;
    stalls = 0;
    while (stall && stalls < 10) begin
      stalls++;
      @(negedge clk); #2;
    end
    fwd = fwdBaseOc2;
  endtask

  task automatic flush();
    @(negedge clk);
    dsValid = 0; dsBaseUse = 0; dsIdxUse = 0; dsDestWr = 0;
    dsBranchPair = 0; dsMovePair = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic testReset();
    #2;
    chk("R1 oagValid after reset", int'(oagValid), 0);
    @(negedge clk);
    dsValid = 1; dsBaseUse = 1; dsBaseReg = 4'd5; dsIdxUse = 1; dsIdxReg = 4'd9;
    #2;
    chk("R1 stall after reset", int'(stall), 0);
    flush();
    #2;
    chk("R2 stall with dsValid low", int'(stall), 0);
  endtask

  task automatic testExecBase();
    int s; logic f;
    send(0, 0, 0, 0, 1, 4'd9, 0, s, f);
    send(1, 4'd9, 0, 0, 0, 0, 0, s, f);
    chk("R3 exec->base stall cycles", s, 3);
    chk("R5 no forward for exec result", int'(f), 0);
    chk("R9 bubble in AG after stall", int'(oagValid), 0);
    flush();
  endtask

  task automatic testLoadBase();
    int s; logic f;
    send(0, 0, 0, 0, 1, 4'd10, 1, s, f);
    send(1, 4'd10, 0, 0, 0, 0, 0, s, f);
    chk("R4 load->base stall cycles", s, 2);
    chk("R5 forward from OP2 at release", int'(f), 1);
    flush();
  endtask

  task automatic testIndex();
    int s; logic f;
    send(0, 0, 0, 0, 1, 4'd2, 0, s, f);
    send(0, 0, 1, 4'd2, 0, 0, 0, s, f);
    chk("R6 exec->index stall cycles", s, 2);
    flush();
    send(0, 0, 0, 0, 1, 4'd3, 1, s, f);
    send(0, 0, 1, 4'd3, 0, 0, 0, s, f);
    chk("R6 load->index stall cycles", s, 1);
    flush();
  endtask

  task automatic testGapAndNoMatch();
    int s; logic f;
    send(0, 0, 0, 0, 1, 4'd11, 0, s, f);
    send(0, 0, 0, 0, 0, 0, 0, s, f);
    send(1, 4'd11, 0, 0, 0, 0, 0, s, f);
    chk("R10 one instruction gap shortens stall", s, 2);
    flush();
    send(0, 0, 0, 0, 1, 4'd12, 0, s, f);
    send(1, 4'd13, 1, 4'd4, 0, 0, 0, s, f);
    chk("R2 no matching source", s, 0);
    flush();
    send(0, 0, 0, 0, 0, 4'd14, 0, s, f);
    send(1, 4'd14, 0, 0, 0, 0, 0, s, f);
    chk("R10 non-writing producer", s, 0);
    flush();
  endtask

  task automatic testYoungest();
    int s; logic f;
    send(0, 0, 0, 0, 1, 4'd8, 0, s, f);
    send(0, 0, 0, 0, 1, 4'd8, 1, s, f);
    send(1, 4'd8, 0, 0, 0, 0, 0, s, f);
    chk("R7 younger load decides stall", s, 2);
    chk("R7 younger load selects forward", int'(f), 1);
    flush();
    send(0, 0, 0, 0, 1, 4'd8, 1, s, f);
    send(0, 0, 0, 0, 1, 4'd8, 0, s, f);
    send(1, 4'd8, 0, 0, 0, 0, 0, s, f);
    chk("R7 younger exec decides stall", s, 3);
    chk("R7 older load not forwarded", int'(f), 0);
    flush();
  endtask

  task automatic testFold();
    int s; logic f;
    @(negedge clk);
    dsValid = 1; dsBranchPair = 1; dsMovePair = 1;
    cfgBranchFoldOff = 0; cfgMovePairOff = 0;
    #2;
    chk("R8 branch fold enabled", int'(foldBranch), 1);
    chk("R8 move pair enabled", int'(foldMove), 1);
    @(negedge clk);
    cfgBranchFoldOff = 1;
    #2;
    chk("R8 branch fold disabled", int'(foldBranch), 0);
    chk("R8 move pair still on", int'(foldMove), 1);
    @(negedge clk);
    cfgBranchFoldOff = 0; cfgMovePairOff = 1;
    #2;
    chk("R8 move pair disabled", int'(foldMove), 0);
    chk("R8 branch fold back on", int'(foldBranch), 1);
    @(negedge clk);
    cfgMovePairOff = 0; dsBranchPair = 0; dsMovePair = 0;
    flush();
    send(0, 0, 0, 0, 1, 4'd1, 0, s, f);
    @(negedge clk);
    dsValid = 1; dsBaseUse = 1; dsBaseReg = 4'd1; dsDestWr = 0; dsBranchPair = 1;
    #2;
    chk("R9 stall raised for fold test", int'(stall), 1);
    chk("R8 no fold while stalled", int'(foldBranch), 0);
    flush();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    testReset();
    testExecBase();
    testLoadBase();
    testIndex();
    testGapAndNoMatch();
    testYoungest();
    testFold();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule